// File: doc/BRIEF.md
# PLL Divider Parameter Encoder

This block turns a requested PLL feedback ratio, given as a multiplier N and a divider M, into the derived loop parameters P, Q and R. It packs them into four configuration bytes that a separate register-write engine can ship to a clock synthesizer. It also looks at the resulting oscillator frequency, reference × N / M, and chooses a two-bit oscillator range code. When N or M is zero, or N equals M, there is no ratio to program. The block then reports bypass and leaves the parameters uncomputed.

A controller presents N, M and the reference frequency in hertz and pulses `start`. Both divisions run on one shared restoring divider that produces one quotient bit per cycle. When the result is ready the block raises `done` for one cycle. The bytes and flags then hold until the next accepted start. A ratio that cannot be encoded raises an error flag instead and zeroes the bytes.

Top module: `pll_param_encoder`

## Requirements
- R1: When N = 0, M = 0 or N = M at an accepted start, `bypass_o` is 1, `err_o` is 0 and all four bytes are 0 in the cycle after that start, and `done_o` pulses in that same cycle.
- R2: With r0 = floor(N/M), P is 0 when r0 ≥ 16 and otherwise equals 4 minus floor(log2 r0), with r0 = 0 treated like r0 = 1 (P = 4). P appears in byte 3 bits [4:2].
- R3: Q = floor(N·2^P / M) and R = N·2^P − M·Q.
- R4: When Q < 16, Q > 63 or R > 511, `err_o` is 1 and all bytes are 0 at `done_o`. The error flag then stays 1 until the next accepted start clears it.
- R5: Byte 0 = N[11:4]; byte 1 = {N[3:0], R[8:5]}; byte 2 = {R[4:0], Q[5:3]}; byte 3 = {Q[2:0], P[2:0], range[1:0]}, with the MSB written first.
- R6: With f = floor(ref·N/M), the range code in byte 3 bits [1:0] is 3 for f ≥ 175 000 000, 2 for f ≥ 150 000 000, 1 for f ≥ 125 000 000 and 0 otherwise.
- R7: `done_o` is high for exactly one cycle per accepted start. The bytes and flags shown with it hold until the next accepted start.
- R8: A `start` that arrives while a computation is in progress is ignored. It does not change the result, and it produces no extra `done_o`.
- R9: After reset, `done_o`, `bypass_o`, `err_o` and all four bytes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new encoding; accepted only when idle |
| mult_n | input | 12 | Feedback multiplier N |
| div_m | input | 9 | Reference divider M |
| ref_hz | input | 32 | Reference frequency in Hz |
| cfg_b0 | output | 8 | Configuration byte 0 |
| cfg_b1 | output | 8 | Configuration byte 1 |
| cfg_b2 | output | 8 | Configuration byte 2 |
| cfg_b3 | output | 8 | Configuration byte 3 |
| bypass_o | output | 1 | Ratio is trivial; no parameters computed |
| err_o | output | 1 | Ratio cannot be encoded |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that the divider never starts with a zero divisor. The bypass filter is what guarantees this, since any request with M = 0 is diverted before a division begins. They also assume that the range thresholds rise strictly from level to level. The inputs are sampled only on an accepted start, so the bench changes N, M and the reference only at falling edges. It holds `start` high for a single cycle. It also sends one deliberate start in the middle of a computation, with different operands, to confirm that they are ignored.

// File: rtl/pllenc_pkg.sv
package pllenc_pkg;

  localparam int N_W     = 12;
  localparam int M_W     = 9;
  localparam int P_MAX   = 4;
  localparam int P_W     = 3;
  localparam int NN_W    = N_W + P_MAX;
  localparam int P_SAT   = 2 ** P_MAX;
  localparam int Q_MIN   = 16;
  localparam int Q_MAX   = 63;
  localparam int Q_FLD_W = 6;
  localparam int R_MAX   = 511;
  localparam int RNG_W   = 2;
  localparam int RNG_LVL = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RATIO = 2'd1,
    ST_SPLIT = 2'd2
  } enc_state_e;

  typedef struct packed {
    logic [7:0] b3;
    logic [7:0] b2;
    logic [7:0] b1;
    logic [7:0] b0;
  } cfg_bytes_t;

  function automatic logic is_bypass(input logic [N_W-1:0] n, input logic [M_W-1:0] m);
    return (n == '0) || (m == '0) || (NN_W'(n) == NN_W'(m));
  endfunction

  // Halve the ratio until it reaches one, counting down from P_MAX.
  function automatic logic [P_W-1:0] derive_p(input logic [NN_W-1:0] ratio);
    logic [NN_W-1:0] r;
    logic [P_W-1:0]  p;
    if (ratio >= NN_W'(P_SAT)) return '0;
    r = ratio;
    p = P_W'(P_MAX);
    for (int i = 0; i < P_MAX; i++) begin
      if (r > NN_W'(1)) begin
        r = r >> 1;
        p = p - P_W'(1);
      end
    end
    return p;
  endfunction

  function automatic logic [NN_W-1:0] scale_n(input logic [N_W-1:0] n, input logic [P_W-1:0] p);
    return NN_W'(n) << p;
  endfunction

  function automatic logic split_invalid(input logic [NN_W-1:0] q, input logic [NN_W-1:0] r);
    return (q < NN_W'(Q_MIN)) || (q > NN_W'(Q_MAX)) || (r > NN_W'(R_MAX));
  endfunction

endpackage

// File: rtl/pllenc_divider.sv
module pllenc_divider #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy_o,
  output logic             fin_o,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] acc;
  logic [DVS_W-1:0] dvs_q;
  logic [DVD_W-1:0] shq;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             fin;

  logic [DVS_W:0] trial;
  logic [DVS_W:0] diff;
  logic           take;

  assign trial = {acc, shq[DVD_W-1]};
  assign take  = trial >= {1'b0, dvs_q};
  assign diff  = trial - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      dvs_q <= '0;
      shq   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc   <= '0;
        dvs_q <= divisor;
        shq   <= dividend;
        cnt   <= CNT_W'(DVD_W);
        busy  <= 1'b1;
      end else if (busy) begin
        acc <= take ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        shq <= {shq[DVD_W-2:0], take};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy;
  assign fin_o  = fin;
  assign quo_o  = shq;
  assign rem_o  = acc;

  a_r3_nonzero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> divisor != '0);

  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> rem_o < dvs_q);

  a_r3_fin_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> ($past(busy) && !busy_o));

endmodule

// File: rtl/pllenc_range.sv
module pllenc_range
  import pllenc_pkg::*;
#(
  parameter int               F_W   = 32,
  parameter logic [F_W-1:0]   TH_LO = 32'd125_000_000,
  parameter logic [F_W-1:0]   TH_MD = 32'd150_000_000,
  parameter logic [F_W-1:0]   TH_HI = 32'd175_000_000
) (
  input  logic [F_W-1:0]   ref_hz,
  input  logic [N_W-1:0]   n,
  input  logic [M_W-1:0]   m,
  output logic [RNG_W-1:0] code
);
  localparam int PW = F_W + N_W + M_W;
  localparam logic [F_W-1:0] TH [RNG_LVL] = '{TH_LO, TH_MD, TH_HI};

  logic [PW-1:0]      lhs;
  logic [RNG_LVL-1:0] above;

  // floor(ref*n/m) >= T  <=>  ref*n >= T*m, so no third division is needed.
  assign lhs = PW'(ref_hz) * PW'(n);

  for (genvar k = 0; k < RNG_LVL; k++) begin : g_lvl
    assign above[k] = lhs >= (PW'(TH[k]) * PW'(m));
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < RNG_LVL; k++) begin
      if (above[k]) code = RNG_W'(k + 1);
    end
  end

  always_comb begin
    a_r6_thermometer: assert (!(above[2] && !above[1]) && !(above[1] && !above[0]));
  end

endmodule

// File: rtl/pllenc_pack.sv
module pllenc_pack
  import pllenc_pkg::*;
(
  input  logic [N_W-1:0]     n,
  input  logic [M_W-1:0]     r,
  input  logic [Q_FLD_W-1:0] q,
  input  logic [P_W-1:0]     p,
  input  logic [RNG_W-1:0]   rng,
  output cfg_bytes_t         bytes_o
);
  always_comb begin
    bytes_o.b0 = n[11:4];
    bytes_o.b1 = {n[3:0], r[8:5]};
    bytes_o.b2 = {r[4:0], q[5:3]};
    bytes_o.b3 = {q[2:0], p, rng};
  end
endmodule

// File: rtl/pll_param_encoder.sv
module pll_param_encoder
  import pllenc_pkg::*;
#(
  parameter int             F_W   = 32,
  parameter logic [F_W-1:0] TH_LO = 32'd125_000_000,
  parameter logic [F_W-1:0] TH_MD = 32'd150_000_000,
  parameter logic [F_W-1:0] TH_HI = 32'd175_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [11:0]    mult_n,
  input  logic [8:0]     div_m,
  input  logic [F_W-1:0] ref_hz,
  output logic [7:0]     cfg_b0,
  output logic [7:0]     cfg_b1,
  output logic [7:0]     cfg_b2,
  output logic [7:0]     cfg_b3,
  output logic           bypass_o,
  output logic           err_o,
  output logic           done_o
);
  enc_state_e     state;
  logic [N_W-1:0] n_q;
  logic [M_W-1:0] m_q;
  logic [F_W-1:0] ref_q;
  logic [P_W-1:0] p_q;
  cfg_bytes_t     cfg_q;

  logic             accept;
  logic             byp_req;
  logic             ratio_done;
  logic             split_done;
  logic             split_bad;
  logic [P_W-1:0]   p_next;
  logic [NN_W-1:0]  nn_w;

  logic             div_go;
  logic [NN_W-1:0]  div_dvd;
  logic [M_W-1:0]   div_dvs;
  logic             div_busy;
  logic             div_fin;
  logic [NN_W-1:0]  div_quo;
  logic [M_W-1:0]   div_rem;

  logic [RNG_W-1:0] rng_code;
  cfg_bytes_t       packed_w;

  assign accept     = (state == ST_IDLE) && start;
  assign byp_req    = is_bypass(mult_n, div_m);
  assign ratio_done = (state == ST_RATIO) && div_fin;
  assign split_done = (state == ST_SPLIT) && div_fin;
  assign p_next     = derive_p(div_quo);
  assign nn_w       = scale_n(n_q, p_next);
  assign split_bad  = split_invalid(div_quo, NN_W'(div_rem));

  assign div_go  = (accept && !byp_req) || ratio_done;
  assign div_dvd = accept ? NN_W'(mult_n) : nn_w;
  assign div_dvs = accept ? div_m : m_q;

  pllenc_divider #(
    .DVD_W (NN_W),
    .DVS_W (M_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy_o   (div_busy),
    .fin_o    (div_fin),
    .quo_o    (div_quo),
    .rem_o    (div_rem)
  );

  pllenc_range #(
    .F_W   (F_W),
    .TH_LO (TH_LO),
    .TH_MD (TH_MD),
    .TH_HI (TH_HI)
  ) u_range (
    .ref_hz (ref_q),
    .n      (n_q),
    .m      (m_q),
    .code   (rng_code)
  );

  pllenc_pack u_pack (
    .n       (n_q),
    .r       (div_rem),
    .q       (div_quo[Q_FLD_W-1:0]),
    .p       (p_q),
    .rng     (rng_code),
    .bytes_o (packed_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      n_q      <= '0;
      m_q      <= '0;
      ref_q    <= '0;
      p_q      <= '0;
      cfg_q    <= '0;
      bypass_o <= 1'b0;
      err_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            n_q      <= mult_n;
            m_q      <= div_m;
            ref_q    <= ref_hz;
            cfg_q    <= '0;
            err_o    <= 1'b0;
            bypass_o <= byp_req;
            if (byp_req) done_o <= 1'b1;
            else         state  <= ST_RATIO;
          end
        end
        ST_RATIO: begin
          if (ratio_done) begin
            p_q   <= p_next;
            state <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          if (split_done) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
            if (split_bad) err_o <= 1'b1;
            else           cfg_q <= packed_w;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cfg_b0 = cfg_q.b0;
  assign cfg_b1 = cfg_q.b1;
  assign cfg_b2 = cfg_q.b2;
  assign cfg_b3 = cfg_q.b3;

  a_r1_bypass_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && byp_req) |=> (done_o && bypass_o && !err_o));

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass_o && err_o));

  a_r2_p_field_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !bypass_o && !err_o) |-> (cfg_b3[4:2] <= 3'd4));

  a_r4_q_field_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !bypass_o && !err_o) |-> ({cfg_b2[2:0], cfg_b3[7:5]} >= 6'd16));

  a_r4_err_bytes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ({cfg_b3, cfg_b2, cfg_b1, cfg_b0} == 32'd0));

  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start) |=> err_o);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state == ST_IDLE && !div_busy));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> $stable(n_q) && $stable(m_q));

endmodule

// File: tb/pll_param_encoder_tb_top.sv
`timescale 1ns/1ps
module pll_param_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] mult_n = '0;
  logic [8:0]  div_m = '0;
  logic [31:0] ref_hz = '0;
  logic [7:0]  cfg_b0, cfg_b1, cfg_b2, cfg_b3;
  logic        bypass_o, err_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pll_param_encoder dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mult_n   (mult_n),
    .div_m    (div_m),
    .ref_hz   (ref_hz),
    .cfg_b0   (cfg_b0),
    .cfg_b1   (cfg_b1),
    .cfg_b2   (cfg_b2),
    .cfg_b3   (cfg_b3),
    .bypass_o (bypass_o),
    .err_o    (err_o),
    .done_o   (done_o)
  );

  // {n[12], m[9], ref[32], bypass, err}
  localparam int NV = 14;
  localparam logic [54:0] VEC [NV] = '{
    {12'd8,    9'd1,   32'd25_000_000, 1'b0, 1'b0},
    {12'd6,    9'd1,   32'd25_000_000, 1'b0, 1'b0},
    {12'd5,    9'd1,   32'd25_000_000, 1'b0, 1'b0},
    {12'd49,   9'd10,  32'd25_000_000, 1'b0, 1'b0},
    {12'd4095, 9'd1,   32'd25_000_000, 1'b0, 1'b1},
    {12'd1,    9'd2,   32'd25_000_000, 1'b0, 1'b1},
    {12'd0,    9'd5,   32'd25_000_000, 1'b1, 1'b0},
    {12'd7,    9'd0,   32'd25_000_000, 1'b1, 1'b0},
    {12'd300,  9'd300, 32'd25_000_000, 1'b1, 1'b0},
    {12'd4000, 9'd511, 32'd25_000_000, 1'b0, 1'b0},
    {12'd1000, 9'd311, 32'd40_000_000, 1'b0, 1'b0},
    {12'd16,   9'd1,   32'd10_000_000, 1'b0, 1'b0},
    {12'd15,   9'd1,   32'd10_000_000, 1'b0, 1'b0},
    {12'd7,    9'd1,   32'd24_999_999, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Independent model: highest set bit of the ratio, then fields.
  function automatic logic [31:0] model_bytes(input longint n, input longint m, input longint rf);
    longint r0, p, nn, q, r, f, rng;
    int hb;
    logic [11:0] nb;
    logic [8:0]  rb;
    logic [5:0]  qb;
    r0 = n / m;
    hb = 0;
    for (int i = 0; i < 16; i++) if ((r0 >> i) != 0) hb = i;
    if (r0 >= 16)     p = 0;
    else if (r0 == 0) p = 4;
    else              p = 4 - hb;
    nn = n * (longint'(1) << p);
    q  = nn / m;
    r  = nn - m * q;
    f  = (rf * n) / m;
    rng = (f >= 175_000_000) ? 3 : (f >= 150_000_000) ? 2 : (f >= 125_000_000) ? 1 : 0;
    nb = 12'(n); rb = 9'(r); qb = 6'(q);
    return {qb[2:0], 3'(p), 2'(rng), rb[4:0], qb[5:3], nb[3:0], rb[8:5], nb[11:4]};
  endfunction

  function automatic logic [31:0] got_bytes();
    return {cfg_b3, cfg_b2, cfg_b1, cfg_b0};
  endfunction

  task automatic pulse_start(input logic [11:0] n, input logic [8:0] m, input logic [31:0] rf);
    mult_n = n; div_m = m; ref_hz = rf;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n_cyc = 0;
    while (!done_o && n_cyc < 200) begin
      @(negedge clk);
      n_cyc++;
    end
    chk(done_o, tag, 0, 1);
  endtask

  task automatic finish_report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    finish_report();
  end

  initial begin
    logic [31:0] exp_b;
    int dn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(got_bytes() == 0 && !done_o && !bypass_o && !err_o, "R9 reset outputs",
        {got_bytes(), done_o, bypass_o, err_o}, 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      pulse_start(v[54:43], v[42:34], v[33:2]);
      wait_done("R7 done strobe");
      chk(bypass_o == v[1], "R1 bypass flag", bypass_o, v[1]);
      chk(err_o == v[0], "R4 error flag", err_o, v[0]);
      exp_b = (v[1] || v[0]) ? 32'd0 : model_bytes(v[54:43], v[42:34], v[33:2]);
      chk(got_bytes() == exp_b, "R5 R2 R3 R6 packed bytes", got_bytes(), exp_b);
      @(negedge clk);
      chk(!done_o, "R7 done single cycle", done_o, 0);
      chk(got_bytes() == exp_b, "R7 bytes held", got_bytes(), exp_b);
    end

    // R1: bypass reports in the cycle right after start
    pulse_start(12'd9, 9'd9, 32'd25_000_000);
    chk(done_o && bypass_o, "R1 bypass latency", {done_o, bypass_o}, 2'b11);

    // R8: start during computation is ignored
    pulse_start(12'd4000, 9'd511, 32'd25_000_000);
    repeat (3) @(negedge clk);
    pulse_start(12'd8, 9'd1, 32'd10_000_000);
    dn = 0;
    exp_b = model_bytes(4000, 511, 25_000_000);
    for (int c = 0; c < 80; c++) begin
      if (done_o) begin
        dn++;
        if (dn == 1) chk(got_bytes() == exp_b, "R8 result from first start", got_bytes(), exp_b);
      end
      @(negedge clk);
    end
    chk(dn == 1, "R8 single done", dn, 1);

    // R4: error holds until the next start, bytes zero
    pulse_start(12'd4095, 9'd1, 32'd25_000_000);
    wait_done("R4 done");
    repeat (10) @(negedge clk);
    chk(err_o == 1'b1, "R4 error held", err_o, 1);
    chk(got_bytes() == 0, "R4 bytes zero on error", got_bytes(), 0);
    pulse_start(12'd6, 9'd1, 32'd25_000_000);
    chk(err_o == 1'b0, "R4 error cleared by start", err_o, 0);
    wait_done("R4 done after clear");
    exp_b = model_bytes(6, 1, 25_000_000);
    chk(!err_o && got_bytes() == exp_b, "R4 valid after clear", got_bytes(), exp_b);

    finish_report();
  end

endmodule